// File: doc/BRIEF.md
# Two-Road Traffic Light Controller

This block is a four-state Moore machine that alternates right of way between two crossing roads. Each road has a traffic sensor input and a two-bit lamp output. Road A keeps green for as long as its sensor reports waiting traffic. When that sensor drops, A shows yellow for exactly one cycle. Road B then gets green and keeps it while its own sensor reports traffic. B then shows yellow for one cycle and the road returns to A.

The state register uses a fixed binary encoding. Its next value comes from an XOR term and a sum-of-products term. The lamp codes are decoded from the state bits. Both lamp outputs are registered. They are loaded from the decoded next state, so they change on the same clock edge as the state itself. Reset is synchronous and active high.

Top module: `traffic_light_ctrl`

## Requirements
- R1: A clock edge with `rst` high puts road A on green and road B on red, whatever the sensors show, and this holds in the cycle after reset is released.
- R2: While A is green and `sense_a` is high at a clock edge, A stays green and B stays red.
- R3: While A is green and `sense_a` is low at a clock edge, the next cycle shows A yellow and B red.
- R4: A yellow lasts exactly one cycle. It is followed by A red and B green, for any sensor values.
- R5: While B is green and `sense_b` is high at a clock edge, B stays green and A stays red.
- R6: While B is green and `sense_b` is low at a clock edge, the next cycle shows B yellow and A red.
- R7: B yellow lasts exactly one cycle. It is followed by A green and B red, for any sensor values.
- R8: Lamp codes are green = 2'b00, yellow = 2'b01 and red = 2'b10. Code 2'b11 never appears, and the two lamps are never non-red at the same time.
- R9: `sense_b` has no effect while A is green, and `sense_a` has no effect while B is green.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_a | input | 1 | Traffic waiting on road A |
| sense_b | input | 1 | Traffic waiting on road B |
| lamp_a | output | 2 | Registered lamp code for road A |
| lamp_b | output | 2 | Registered lamp code for road B |

## Verification
The hardest case to reach is a reset that arrives while road B holds green. To get there, the stimulus must first drop `sense_a`, pass through the yellow state, and then hold `sense_b` high. The directed sequence does this and then pulses reset with both sensors high, to confirm that B's grant is discarded. The two single-cycle yellow states are driven with sensor values that would hold a green, which shows that neither yellow can be stretched. While each road is green, the other road's sensor is toggled, to show that it has no effect.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  localparam int LAMP_W = 2;
  localparam int ST_W   = 2;

  typedef logic [LAMP_W-1:0] lamp_t;
  typedef logic [ST_W-1:0]   st_t;

  typedef enum logic [ST_W-1:0] {
    ST_A_GO   = 2'b00,
    ST_A_WARN = 2'b01,
    ST_B_GO   = 2'b10,
    ST_B_WARN = 2'b11
  } tlc_state_t;

  localparam lamp_t LAMP_GREEN  = 2'b00;
  localparam lamp_t LAMP_YELLOW = 2'b01;
  localparam lamp_t LAMP_RED    = 2'b10;
endpackage

// File: rtl/tlc_next_state.sv
module tlc_next_state
  import tlc_pkg::*;
(
  input  st_t  cur,
  input  logic sense_a,
  input  logic sense_b,
  output st_t  nxt
);
  logic hi, lo;
  assign hi = cur[1];
  assign lo = cur[0];

  always_comb begin
    nxt[1] = hi ^ lo;
    nxt[0] = (~hi & ~lo & ~sense_a) | (hi & ~lo & ~sense_b);
  end
endmodule

// File: rtl/tlc_lamp_decode.sv
module tlc_lamp_decode
  import tlc_pkg::*;
#(
  parameter bit ROAD_B = 1'b0
)(
  input  st_t   st,
  output lamp_t lamp
);
  generate
    if (ROAD_B == 1'b0) begin : g_road_a
      assign lamp = {st[1], ~st[1] & st[0]};
    end else begin : g_road_b
      assign lamp = {~st[1], st[1] & st[0]};
    end
  endgenerate
endmodule

// File: rtl/traffic_light_ctrl.sv
module traffic_light_ctrl
  import tlc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sense_a,
  input  logic              sense_b,
  output logic [LAMP_W-1:0] lamp_a,
  output logic [LAMP_W-1:0] lamp_b
);
  tlc_state_t st_q;
  st_t        st_d;
  lamp_t      lamp_a_d, lamp_b_d;

  tlc_next_state u_next (
    .cur     (st_t'(st_q)),
    .sense_a (sense_a),
    .sense_b (sense_b),
    .nxt     (st_d)
  );

  tlc_lamp_decode #(.ROAD_B(1'b0)) u_dec_a (
    .st   (st_d),
    .lamp (lamp_a_d)
  );

  tlc_lamp_decode #(.ROAD_B(1'b1)) u_dec_b (
    .st   (st_d),
    .lamp (lamp_b_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_A_GO;
      lamp_a <= LAMP_GREEN;
      lamp_b <= LAMP_RED;
    end else begin
      st_q   <= tlc_state_t'(st_d);
      lamp_a <= lamp_a_d;
      lamp_b <= lamp_b_d;
    end
  end
endmodule

// File: rtl/traffic_light_ctrl_chk.sv
module traffic_light_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       sense_a,
  input logic       sense_b,
  input logic [1:0] lamp_a,
  input logic [1:0] lamp_b
);
  localparam logic [1:0] G = 2'b00;
  localparam logic [1:0] Y = 2'b01;
  localparam logic [1:0] R = 2'b10;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (lamp_a == G && lamp_b == R));

  // R2
  a_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lamp_a == G && sense_a) |=> (lamp_a == G && lamp_b == R));

  // R3
  a_warn_chk: assert property (@(posedge clk) disable iff (rst)
    (lamp_a == G && !sense_a) |=> (lamp_a == Y && lamp_b == R));

  // R4
  a_yellow_once_chk: assert property (@(posedge clk) disable iff (rst)
    (lamp_a == Y) |=> (lamp_a == R && lamp_b == G));

  // R5
  b_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lamp_b == G && sense_b) |=> (lamp_b == G && lamp_a == R));

  // R6
  b_warn_chk: assert property (@(posedge clk) disable iff (rst)
    (lamp_b == G && !sense_b) |=> (lamp_b == Y && lamp_a == R));

  // R7
  b_yellow_once_chk: assert property (@(posedge clk) disable iff (rst)
    (lamp_b == Y) |=> (lamp_a == G && lamp_b == R));

  // R8
  one_road_open_chk: assert property (@(posedge clk) disable iff (rst)
    (lamp_a == R || lamp_b == R) && lamp_a != 2'b11 && lamp_b != 2'b11);

  // R8
  a_green_to_yellow_chk: assert property (@(posedge clk) disable iff (rst)
    (lamp_a == G) |=> (lamp_a == G || lamp_a == Y));

  // R8
  b_green_to_yellow_chk: assert property (@(posedge clk) disable iff (rst)
    (lamp_b == G) |=> (lamp_b == G || lamp_b == Y));
endmodule

bind traffic_light_ctrl traffic_light_ctrl_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .sense_a (sense_a),
  .sense_b (sense_b),
  .lamp_a  (lamp_a),
  .lamp_b  (lamp_b)
);

// File: tb/traffic_light_ctrl_test.sv
module traffic_light_ctrl_test;
  localparam logic [1:0] G = 2'b00;
  localparam logic [1:0] Y = 2'b01;
  localparam logic [1:0] R = 2'b10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sense_a = 1'b0;
  logic       sense_b = 1'b0;
  logic [1:0] lamp_a, lamp_b;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  traffic_light_ctrl uut (
    .clk     (clk),
    .rst     (rst),
    .sense_a (sense_a),
    .sense_b (sense_b),
    .lamp_a  (lamp_a),
    .lamp_b  (lamp_b)
  );

  task automatic chk(input string req, input logic [1:0] ea, input logic [1:0] eb);
    total++;
    if (lamp_a !== ea || lamp_b !== eb) begin
      bad++;
      $display("FAIL %s: got a=%b b=%b exp a=%b b=%b", req, lamp_a, lamp_b, ea, eb);
    end
    total++;
    if (!(lamp_a === R || lamp_b === R) || lamp_a === 2'b11 || lamp_b === 2'b11) begin
      bad++;
      $display("FAIL R8: got a=%b b=%b exp one lamp red, no 11", lamp_a, lamp_b);
    end
  endtask

  task automatic step(input logic r, input logic a, input logic b);
    @(negedge clk);
    rst = r; sense_a = a; sense_b = b;
    @(posedge clk);
    #3;
  endtask

  task automatic t_reset();
    step(1, 1, 1);
    chk("R1 reset", G, R);
    step(0, 1, 0);
    chk("R1 after release", G, R);
  endtask

  task automatic t_hold_a();
    for (int i = 0; i < 4; i++) begin
      step(0, 1, i[0]);
      chk("R2/R9 A holds, sense_b ignored", G, R);
    end
  endtask

  task automatic t_rotation();
    step(0, 0, 1);
    chk("R3 A yellow", Y, R);
    step(0, 1, 1);
    chk("R4 A yellow one cycle", R, G);
    for (int i = 0; i < 4; i++) begin
      step(0, i[0], 1);
      chk("R5/R9 B holds, sense_a ignored", R, G);
    end
    step(0, 1, 0);
    chk("R6 B yellow", R, Y);
    step(0, 0, 1);
    chk("R7 B yellow one cycle", G, R);
    step(0, 0, 0);
    chk("R3 A yellow second pass", Y, R);
    step(0, 0, 0);
    chk("R4 B green with idle sensors", R, G);
    step(0, 0, 0);
    chk("R6 B yellow idle", R, Y);
    step(0, 1, 1);
    chk("R7 back to A", G, R);
  endtask

  task automatic t_reset_mid_b();
    step(0, 0, 1);
    chk("R3 A yellow before B", Y, R);
    step(0, 0, 1);
    chk("R4 B green before reset", R, G);
    step(1, 1, 1);
    chk("R1 reset while B green", G, R);
    step(0, 1, 1);
    chk("R1 held after mid reset", G, R);
  endtask

  initial begin
    t_reset();
    t_hold_a();
    t_rotation();
    t_reset_mid_b();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=hung exp=complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule